// File: doc/BRIEF.md
# Free-Running Timer with Input Capture

A 16-bit up-counter for a processor's local peripheral bus. It advances on a clock picked from three internal divided rates or an external clock input. Two compare registers and a wrap detector raise flags. A capture strobe from another processor copies the counter into a capture register and raises its own flag. Each flag has an enable, and the enabled flags are combined onto one interrupt request line.

Software uses an 8-bit register port. The counter, the compare registers and the capture register are 16 bits wide, so they are reached as high and low bytes. Reading a high byte stores the matching low byte at the same moment, which keeps the 16-bit value consistent across the two accesses. A 16-bit write takes effect in full when the low byte is written. A flag is cleared by writing 0 to its bit.

Top module: `fr_timer`

## Requirements
- R1: After reset the counter and capture register are 0, both compare registers are 0xFFFF, the clock select, enables and flags are 0, and irq_o is low.
- R2: Clock select (address 0, bits 1:0) codes 0, 1 and 2 make the counter advance once every 8, 32 and 128 clocks. A write to address 0 or to the counter low byte restarts the divider phase, so the first step comes a full period after that write.
- R3: With select code 3 the counter advances once for each rising edge of ext_clk_i. The edge is seen through a two-flop synchroniser, and the internal divider has no effect in this mode.
- R4: A read of a high byte (counter 3, capture 9) returns bits 15:8 and stores bits 7:0 of the same register in one cycle. The next low-byte read (counter 4, capture 10) returns that stored byte, even if the counter has moved since. A write to a high byte (3, 5, 7) is held, and the write to the matching low byte (4, 6, 8) loads both bytes at once.
- R5: Status bit 1 (compare A, address 5/6) or bit 2 (compare B, address 7/8) is set on the count step that makes the counter equal to that compare register.
- R6: Status bit 3 is set on the count step from 0xFFFF to 0x0000.
- R7: A rising edge on cap_i sets status bit 0 and copies the counter into the capture register. The strobe passes through a two-flop synchroniser, so the flag is set on the third clock edge after cap_i goes high.
- R8: A write to the status register (address 2) clears each flag whose bit is written 0 and leaves each flag whose bit is written 1. A flag event in the same cycle as a clear wins.
- R9: irq_o is high exactly when some status bit and the same bit of the enable register (address 1) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wr_i | input | 1 | Write strobe for one cycle |
| rd_i | input | 1 | Read strobe for one cycle; high-byte reads store the low byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while rd_i is high, zero otherwise |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| cap_i | input | 1 | Capture strobe from the other processor, asynchronous |
| irq_o | output | 1 | Interrupt request |

## Verification
Counting is tried at every divider with random start values and random wait lengths. This tells a wrong divide ratio apart from a divider phase that was not restarted on the load. In external mode a random number of pulses is applied after a long idle stretch, which separates true edge counting from leakage of the internal divider. Compare, wrap and capture are each checked one cycle before and in the cycle of the expected event, which pins down the latency. A low-byte read placed right across a carry from 0x12FF to 0x1300 shows whether the read is atomic. Mixed clear masks and enable masks show that each bit is handled on its own.

// File: rtl/fr_timer_pkg.sv
package fr_timer_pkg;
  localparam int N_CMP = 2;

  localparam logic [3:0] ADR_CTRL   = 4'd0;
  localparam logic [3:0] ADR_IEN    = 4'd1;
  localparam logic [3:0] ADR_STAT   = 4'd2;
  localparam logic [3:0] ADR_CNT_HI = 4'd3;
  localparam logic [3:0] ADR_CNT_LO = 4'd4;
  localparam logic [3:0] ADR_CMP_HI = 4'd5;  // channel g: hi at 5+2g, lo at 6+2g
  localparam logic [3:0] ADR_CAP_HI = 4'd9;
  localparam logic [3:0] ADR_CAP_LO = 4'd10;

  localparam int FLG_CAP  = 0;
  localparam int FLG_CMPA = 1;
  localparam int FLG_CMPB = 2;
  localparam int FLG_OVF  = 3;
  localparam int N_FLG    = 4;

  localparam logic [1:0] SEL_EXT = 2'd3;
endpackage

// File: rtl/fr_timer_sync.sv
module fr_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/fr_timer_presc.sv
module fr_timer_presc import fr_timer_pkg::*; #(
  parameter int DIV_A       = 8,
  parameter int DIV_B       = 32,
  parameter int DIV_C       = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       restart_i,
  input  logic       ext_i,
  output logic       tick_o
);
  localparam int PW = $clog2(DIV_C);

  logic [PW-1:0] pcnt_q, last;
  logic          ext_rise, is_ext;

  fr_timer_sync #(.STAGES(SYNC_STAGES)) ext_sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ext_i),
    .rise_o (ext_rise)
  );

  always_comb begin
    case (sel_i)
      2'd0:    last = PW'(DIV_A - 1);
      2'd1:    last = PW'(DIV_B - 1);
      default: last = PW'(DIV_C - 1);
    endcase
  end

  assign is_ext = (sel_i == SEL_EXT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pcnt_q <= '0;
    else if (restart_i)   pcnt_q <= '0;
    else if (!is_ext)     pcnt_q <= (pcnt_q == last) ? '0 : pcnt_q + 1'b1;
  end

  assign tick_o = is_ext ? ext_rise : (pcnt_q == last);
endmodule

// File: rtl/fr_timer_cnt.sv
module fr_timer_cnt import fr_timer_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] cmp_i [N_CMP],
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic [N_CMP-1:0] match_o
);
  logic [CNT_W-1:0] cnt_q, nxt;
  logic             step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= nxt;
  end

  assign step  = tick_i & ~load_i;
  assign nxt   = cnt_q + 1'b1;
  assign ovf_o = step & (cnt_q == '1);
  assign cnt_o = cnt_q;

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    assign match_o[g] = step & (nxt == cmp_i[g]);
  end
endmodule

// File: rtl/fr_timer.sv
module fr_timer import fr_timer_pkg::*; #(
  parameter int CNT_W       = 16,
  parameter int DIV_A       = 8,
  parameter int DIV_B       = 32,
  parameter int DIV_C       = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       ext_clk_i,
  input  logic       cap_i,
  output logic       irq_o
);
  localparam int DW = CNT_W / 2;

  logic [1:0]       sel_q;
  logic [N_FLG-1:0] ien_q, flg_q, flg_set, flg_keep;
  logic [CNT_W-1:0] cmp_q [N_CMP];
  logic [CNT_W-1:0] cap_q, cnt_w;
  logic [DW-1:0]    wbuf_q, rbuf_q, rd_val;
  logic             tick, cnt_ld, ctrl_wr, stat_wr, wr_hi, cap_evt, ovf;
  logic [N_CMP-1:0] match;

  assign ctrl_wr = wr_i && (addr_i == ADR_CTRL);
  assign stat_wr = wr_i && (addr_i == ADR_STAT);
  assign cnt_ld  = wr_i && (addr_i == ADR_CNT_LO);

  always_comb begin
    wr_hi = wr_i && (addr_i == ADR_CNT_HI);
    for (int g = 0; g < N_CMP; g++)
      if (wr_i && addr_i == ADR_CMP_HI + 4'(2*g)) wr_hi = 1'b1;
  end

  fr_timer_presc #(
    .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .SYNC_STAGES(SYNC_STAGES)
  ) presc_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel_q),
    .restart_i (ctrl_wr | cnt_ld),
    .ext_i     (ext_clk_i),
    .tick_o    (tick)
  );

  fr_timer_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (cnt_ld),
    .load_val_i ({wbuf_q, wdata_i[DW-1:0]}),
    .cmp_i      (cmp_q),
    .cnt_o      (cnt_w),
    .ovf_o      (ovf),
    .match_o    (match)
  );

  fr_timer_sync #(.STAGES(SYNC_STAGES)) cap_sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cap_i),
    .rise_o (cap_evt)
  );

  always_comb begin
    flg_set           = '0;
    flg_set[FLG_CAP]  = cap_evt;
    flg_set[FLG_CMPA] = match[0];
    flg_set[FLG_CMPB] = match[1];
    flg_set[FLG_OVF]  = ovf;
    flg_keep          = stat_wr ? wdata_i[N_FLG-1:0] : '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      ien_q  <= '0;
      flg_q  <= '0;
      cap_q  <= '0;
      wbuf_q <= '0;
      rbuf_q <= '0;
      for (int g = 0; g < N_CMP; g++) cmp_q[g] <= '1;
    end else begin
      flg_q <= (flg_q & flg_keep) | flg_set;  // set wins over clear
      if (ctrl_wr) sel_q <= wdata_i[1:0];
      if (wr_i && addr_i == ADR_IEN) ien_q <= wdata_i[N_FLG-1:0];
      if (wr_hi) wbuf_q <= wdata_i[DW-1:0];
      if (cap_evt) cap_q <= cnt_w;
      for (int g = 0; g < N_CMP; g++)
        if (wr_i && addr_i == ADR_CMP_HI + 4'(2*g+1))
          cmp_q[g] <= {wbuf_q, wdata_i[DW-1:0]};
      if (rd_i && addr_i == ADR_CNT_HI) rbuf_q <= cnt_w[DW-1:0];
      if (rd_i && addr_i == ADR_CAP_HI) rbuf_q <= cap_q[DW-1:0];
    end
  end

  always_comb begin
    case (addr_i)
      ADR_CTRL:               rd_val = DW'(sel_q);
      ADR_IEN:                rd_val = DW'(ien_q);
      ADR_STAT:               rd_val = DW'(flg_q);
      ADR_CNT_HI:             rd_val = cnt_w[CNT_W-1:DW];
      ADR_CAP_HI:             rd_val = cap_q[CNT_W-1:DW];
      ADR_CNT_LO, ADR_CAP_LO: rd_val = rbuf_q;
      default:                rd_val = '0;
    endcase
    for (int g = 0; g < N_CMP; g++) begin
      if (addr_i == ADR_CMP_HI + 4'(2*g))   rd_val = cmp_q[g][CNT_W-1:DW];
      if (addr_i == ADR_CMP_HI + 4'(2*g+1)) rd_val = cmp_q[g][DW-1:0];
    end
  end

  assign rdata_o = rd_i ? rd_val : '0;
  assign irq_o   = |(flg_q & ien_q);
endmodule

// File: rtl/fr_timer_chk.sv
module fr_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic             cnt_ld_i,
  input logic [3:0]       flg_i,
  input logic [3:0]       ien_i,
  input logic             stat_wr_i,
  input logic             cap_evt_i,
  input logic [CNT_W-1:0] cap_val_i,
  input logic [CNT_W-1:0] cmp_a_i
);
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cnt_ld_i) && cnt_i != $past(cnt_i)) |-> cnt_i == CNT_W'($past(cnt_i) + 1'b1)); // R2

  AST_CMP_A_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cnt_ld_i) && cnt_i != $past(cnt_i) && cnt_i == $past(cmp_a_i)) |-> flg_i[1]); // R5

  AST_WRAP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cnt_ld_i) && $past(cnt_i) == '1 && cnt_i == '0) |-> flg_i[3]); // R6

  AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cap_evt_i) |-> $stable(cap_val_i)); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(stat_wr_i) |-> ((flg_i & $past(flg_i)) == $past(flg_i))); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_i == 4'd0) |-> !irq_o); // R9
endmodule

bind fr_timer fr_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_o     (irq_o),
  .cnt_i     (cnt_w),
  .cnt_ld_i  (cnt_ld),
  .flg_i     (flg_q),
  .ien_i     (ien_q),
  .stat_wr_i (stat_wr),
  .cap_evt_i (cap_evt),
  .cap_val_i (cap_q),
  .cmp_a_i   (cmp_q[0])
);

// File: tb/fr_timer_tb_top.sv
module fr_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0, ext = 1'b0, cap = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  fr_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .ext_clk_i(ext), .cap_i(cap), .irq_o(irq)
  );

  function automatic int divof(input int sel);
    return (sel == 0) ? 8 : (sel == 1) ? 32 : 128;
  endfunction

  function automatic logic [15:0] exp_cnt(input logic [15:0] base, input int m, input int div);
    return 16'(base + 16'(m / div));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge; each takes one cycle
  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic ld_cnt(input logic [15:0] v);
    wr_reg(4'd3, v[15:8]);
    wr_reg(4'd4, v[7:0]);
  endtask

  task automatic rd16(input logic [3:0] hi, output logic [15:0] v);
    logic [7:0] h, l;
    rd_reg(hi, h);
    rd_reg(hi + 4'd1, l);
    v = {h, l};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v, base;
    int          m, n;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", irq, 0);
    rd_reg(4'd0, b); chk("R1 ctrl", b, 0);
    rd_reg(4'd1, b); chk("R1 ien", b, 0);
    rd_reg(4'd2, b); chk("R1 stat", b, 0);
    rd16(4'd5, v);   chk("R1 cmpA", v, 16'hFFFF);
    rd16(4'd7, v);   chk("R1 cmpB", v, 16'hFFFF);
    rd16(4'd9, v);   chk("R1 cap", v, 0);
    rd_reg(4'd3, b); chk("R1 cnt hi", b, 0);

    // R2 divided counting, random bases and waits
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 4; k++) begin
        base = 16'($urandom);
        m = $urandom_range(0, 6 * divof(s));
        wr_reg(4'd0, 8'(s));
        ld_cnt(base);
        repeat (m) @(negedge clk);
        rd16(4'd3, v);
        chk($sformatf("R2 sel%0d m%0d", s, m), v, exp_cnt(base, m, divof(s)));
      end
    end

    // R4 atomic read across carry 0x12FF -> 0x1300
    wr_reg(4'd0, 8'd0);
    ld_cnt(16'h12FF);
    repeat (7) @(negedge clk);
    rd16(4'd3, v);
    chk("R4 atomic", v, 16'h12FF);
    rd16(4'd3, v);
    chk("R4 after carry", v, 16'h1300);

    // R3 external clock: idle stretch then random pulse count
    wr_reg(4'd0, 8'd3);
    ld_cnt(16'h0100);
    repeat (300) @(negedge clk);
    rd16(4'd3, v); chk("R3 idle", v, 16'h0100);
    n = $urandom_range(1, 12);
    for (int k = 0; k < n; k++) begin
      ext = 1'b1; repeat (3) @(negedge clk);
      ext = 1'b0; repeat (3) @(negedge clk);
    end
    rd16(4'd3, v); chk("R3 pulses", v, 16'(16'h0100 + n));

    // R5 compare A and B
    for (int k = 0; k < 2; k++) begin
      base = 16'($urandom_range(16'h1000, 16'hEF00));
      n = $urandom_range(1, 20);
      wr_reg(4'd0, 8'd0);
      wr_reg(4'd5, 8'(16'(base + n) >> 8)); wr_reg(4'd6, 8'(base + n));
      wr_reg(4'd7, 8'(16'(base + n + 3) >> 8)); wr_reg(4'd8, 8'(base + n + 3));
      ld_cnt(base);
      wr_reg(4'd2, 8'd0);                       // m = 1
      repeat (8 * n - 2) @(negedge clk);        // m = 8n-1
      rd_reg(4'd2, b); chk("R5 A before", b[1], 0);
      rd_reg(4'd2, b); chk("R5 A at match", b[2:1], 2'b01);
      repeat (22) @(negedge clk);               // m = 8n+23
      rd_reg(4'd2, b); chk("R5 B before", b[2], 0);
      rd_reg(4'd2, b); chk("R5 B at match", b[2], 1);
    end

    // R6 wrap
    ld_cnt(16'hFFFE);
    wr_reg(4'd2, 8'd0);
    repeat (14) @(negedge clk);                 // m = 15
    rd_reg(4'd2, b); chk("R6 before wrap", b[3], 0);
    rd_reg(4'd2, b); chk("R6 at wrap", b, 8'h08);

    // R8 selective clear
    cap = 1'b1; @(negedge clk); cap = 1'b0;
    repeat (5) @(negedge clk);
    rd_reg(4'd2, b); chk("R8 two flags", b, 8'h09);
    wr_reg(4'd2, 8'h07);
    rd_reg(4'd2, b); chk("R8 clear ovf only", b, 8'h01);
    wr_reg(4'd2, 8'h0E);
    rd_reg(4'd2, b); chk("R8 clear cap", b, 8'h00);

    // R7 capture latency and value, R9 gating
    for (int k = 0; k < 3; k++) begin
      base = 16'($urandom_range(16'h1000, 16'hEF00));
      wr_reg(4'd0, 8'd2);
      wr_reg(4'd1, 8'h01);
      ld_cnt(base);                             // m = 0
      cap = 1'b1; @(negedge clk); cap = 1'b0;   // m = 1
      @(negedge clk);                           // m = 2
      chk("R7 irq before", irq, 0);
      @(negedge clk);                           // m = 3
      chk("R7 irq at 3rd edge", irq, 1);
      rd16(4'd9, v); chk("R7 cap value", v, base);
      wr_reg(4'd1, 8'h0E);
      chk("R9 masked", irq, 0);
      wr_reg(4'd1, 8'h01);
      chk("R9 enabled", irq, 1);
      wr_reg(4'd2, 8'h0E);
      chk("R9 flag cleared", irq, 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule